// File: doc/BRIEF.md
# Multi-master two-wire bus byte-write controller

This block is an open-drain master for an I2C bus that other masters may share. On request it waits until the bus is free. It then issues a START, the 7-bit slave address with a write direction bit, one data byte and a STOP. After each byte it checks the slave's acknowledge.

The block never drives a line high. Each line has an output enable that pulls it low, and the pull-ups on the board make the high level, so every device on the bus forms a wired-AND. SCL high time is counted only once the block actually sees SCL high. This lets a slave stretch the clock and lets a faster master shorten a high phase. SDA is compared against the intended bit for arbitration. The first bus fault of a transfer is kept as a numbered code.

Top module: `twm_writer`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block only pulls SDA low while SCL is released when it makes its own START. A complete write shows exactly one START and one STOP on the bus.
- R2: A bus monitor records the most recent bus condition and treats the bus as free after reset. A request waits, with both lines released, while the last condition seen was a START. It proceeds once a STOP is seen.
- R3: The frame is START, then the address MSB first, then a 0 direction bit, then an acknowledge slot, then the data byte MSB first, then an acknowledge slot, then STOP. The first byte on the wire equals {addr, 1'b0}.
- R4: `scl_oe`/`sda_oe` = 1 pulls the line low and 0 releases it. After reset and whenever the block is idle, both are 0.
- R5: The high phase of SCL is counted from the moment the synchronized SCL input reads high. A slave holding SCL low for fewer than STUCK_MAX cycles delays the transfer without corrupting it, and every SCL high phase it produces lasts at least HALF cycles.
- R6: If SDA reads low during SCL high while the block is sending a 1 in an address or data bit, the block loses arbitration. It raises `arb_lost` and error code 2, releases SDA and keeps clocking through that byte's acknowledge slot (9 SCL rising edges in all). It then releases both lines without a STOP.
- R7: If SCL stays low for STUCK_MAX cycles after the block releases it, error code 1 is raised. Both lines are released and the transfer ends with `done`.
- R8: An acknowledge slot that reads SDA high raises error code 3. The block then issues STOP at once, so after a refused address no data byte is sent.
- R9: If SDA still reads low HALF cycles after the block releases it to form the STOP, error code 4 is raised.
- R10: Only the first fault of a transfer is kept. `err_flag` rises with it, and later faults leave `err_code` unchanged. Codes are 0 (none), 1, 2, 3 and 4. Both are cleared when a new request is accepted.
- R11: `req` is taken only while idle. `busy` is high from acceptance until `done`, and `done` is a one-cycle pulse. A request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a write (taken while idle) |
| addr | input | 7 | Slave address |
| data | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_flag | output | 1 | A fault was recorded in this transfer |
| err_code | output | 3 | First fault code (0 none, 1..4) |
| arb_lost | output | 1 | Arbitration was lost in this transfer |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with HALF = 4 and STUCK_MAX = 40. At these values a complete write takes only a few hundred cycles, so one run can sweep many address and data pairs as well as every fault path. A clock stretch of 25 cycles sits inside the 40-cycle watchdog, so the same small setting reaches both the tolerated stretch and the stuck-clock fault. The bench models the wired-AND bus with a slave that can stretch, refuse an acknowledge or jam SDA, and with a second master that can seize SDA.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_SCL_LOW   = 3'd1,
        FLT_SDA_LOW   = 3'd2,
        FLT_NO_ACK    = 3'd3,
        FLT_STOP_HELD = 3'd4
    } fault_e;

    typedef struct packed {
        logic   flag;
        fault_e code;
    } fault_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_SREL, ST_SHIGH, ST_SDROP,
        ST_LOW, ST_RISE, ST_HIGH,
        ST_PLOW, ST_PRISE, ST_PHIGH, ST_PREL, ST_END
    } phase_e;

    // Keep the stored fault unless none is held yet.
    function automatic fault_t fault_keep_first(fault_t cur, fault_e fresh);
        fault_t r;
        r = cur;
        if (!cur.flag && fresh != FLT_NONE) begin
            r.flag = 1'b1;
            r.code = fresh;
        end
        return r;
    endfunction

endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d_in,
    output logic [LINES-1:0] q_out
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-2:0], d_in[g]};
        end
        assign q_out[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/twm_busmon.sv
module twm_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_free
);
    logic scl_p, sda_p;
    logic start_c, stop_c;

    assign start_c = scl_s && scl_p &&  sda_p && !sda_s;
    assign stop_c  = scl_s && scl_p && !sda_p &&  sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bus_free <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_c)     bus_free <= 1'b0;
            else if (stop_c) bus_free <= 1'b1;
        end
    end
endmodule

// File: rtl/twm_writer.sv
module twm_writer
    import twm_pkg::*;
#(
    parameter int HALF      = 8,
    parameter int STUCK_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output logic              busy,
    output logic              done,
    output logic              err_flag,
    output logic [2:0]        err_code,
    output logic              arb_lost,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CMAX  = (STUCK_MAX > HALF) ? STUCK_MAX : HALF;
    localparam int CW    = $clog2(CMAX + 1);
    localparam int SETUP = 2;   // cycles after pulling SCL before SDA may move

    logic [1:0]        line_s;
    logic              scl_s, sda_s, bus_free;
    phase_e            state;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] tx_q, data_q;
    logic [3:0]        bit_idx;
    logic              second_q, lost_q;
    fault_t            err_q;
    fault_e            fault_now;
    logic              ack_slot, hi_exit;

    twm_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_in({scl_in, sda_in}), .q_out(line_s));
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    twm_busmon u_busmon (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .bus_free(bus_free));

    assign ack_slot = (bit_idx == 4'd8);
    assign hi_exit  = (cnt == CW'(HALF - 1)) || !scl_s;

    always_comb begin
        fault_now = FLT_NONE;
        if ((state == ST_SREL || state == ST_RISE || state == ST_PRISE) &&
            !scl_s && cnt == CW'(STUCK_MAX - 1))
            fault_now = FLT_SCL_LOW;
        else if (state == ST_HIGH && scl_s && !ack_slot && !lost_q && tx_q[7] && !sda_s)
            fault_now = FLT_SDA_LOW;
        else if (state == ST_HIGH && hi_exit && ack_slot && !lost_q && sda_s)
            fault_now = FLT_NO_ACK;
        else if (state == ST_PREL && cnt == CW'(HALF - 1) && !sda_s)
            fault_now = FLT_STOP_HELD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            lost_q   <= 1'b0;
            second_q <= 1'b0;
            bit_idx  <= '0;
            tx_q     <= '0;
            data_q   <= '0;
            err_q    <= '{flag: 1'b0, code: FLT_NONE};
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE && req) err_q <= '{flag: 1'b0, code: FLT_NONE};
            else                         err_q <= fault_keep_first(err_q, fault_now);
            case (state)
                ST_IDLE: if (req) begin
                    busy     <= 1'b1;
                    tx_q     <= {addr, 1'b0};
                    data_q   <= data;
                    lost_q   <= 1'b0;
                    second_q <= 1'b0;
                    bit_idx  <= '0;
                    state    <= ST_WAIT;
                end
                ST_WAIT: if (bus_free) begin
                    cnt   <= '0;
                    state <= ST_SREL;
                end
                ST_SREL: begin
                    if (fault_now == FLT_SCL_LOW) state <= ST_END;
                    else if (scl_s && sda_s) begin
                        cnt   <= '0;
                        state <= ST_SHIGH;
                    end else if (!scl_s) cnt <= cnt + 1'b1;
                    else cnt <= '0;
                end
                ST_SHIGH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        sda_oe <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_SDROP;
                    end
                end
                ST_SDROP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        scl_oe <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(SETUP)) sda_oe <= !lost_q && !ack_slot && !tx_q[7];
                    if (cnt == CW'(HALF - 1)) begin
                        scl_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RISE;
                    end
                end
                ST_RISE, ST_PRISE: begin
                    if (scl_s) begin
                        cnt   <= '0;
                        state <= (state == ST_RISE) ? ST_HIGH : ST_PHIGH;
                    end else if (fault_now == FLT_SCL_LOW) begin
                        sda_oe <= 1'b0;
                        state  <= ST_END;
                    end else cnt <= cnt + 1'b1;
                end
                ST_HIGH: begin
                    if (fault_now == FLT_SDA_LOW) lost_q <= 1'b1;
                    cnt <= cnt + 1'b1;
                    if (hi_exit) begin
                        cnt <= '0;
                        if (!ack_slot) begin
                            bit_idx <= bit_idx + 4'd1;
                            tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                            scl_oe  <= 1'b1;
                            state   <= ST_LOW;
                        end else if (lost_q) begin
                            state <= ST_END;
                        end else if (sda_s || second_q) begin
                            scl_oe <= 1'b1;
                            state  <= ST_PLOW;
                        end else begin
                            second_q <= 1'b1;
                            tx_q     <= data_q;
                            bit_idx  <= '0;
                            scl_oe   <= 1'b1;
                            state    <= ST_LOW;
                        end
                    end
                end
                ST_PLOW: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(SETUP)) sda_oe <= 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        scl_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_PRISE;
                    end
                end
                ST_PHIGH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_PREL;
                    end
                end
                ST_PREL: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) state <= ST_END;
                end
                ST_END: begin
                    scl_oe <= 1'b0;
                    sda_oe <= 1'b0;
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign err_flag = err_q.flag;
    assign err_code = err_q.code;
    assign arb_lost = lost_q;

    // R1: SDA is pulled low with SCL released only to form START
    p_start_only_pull_r1: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && !scl_oe) |-> ($past(state) == ST_SHIGH));

    // R2: no progress while the last bus condition was a START
    p_wait_free_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !bus_free) |=> (state == ST_WAIT));

    // R4: both lines released while idle
    p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!sda_oe && !scl_oe));

    // R10: the stored fault does not change during a transfer
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_q.flag && state != ST_IDLE) |=> (err_q.flag && err_q.code == $past(err_q.code)));

    // R10: a raised flag always carries a real code
    p_code_valid_r10: assert property (@(posedge clk) disable iff (rst)
        err_q.flag |-> (err_q.code != FLT_NONE));

    // R11: done lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/twm_writer_bench.sv
module twm_writer_bench;
    localparam int HALF      = 4;
    localparam int STUCK_MAX = 40;
    localparam int STRETCH   = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [6:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic busy, done, err_flag, arb_lost, scl_oe, sda_oe;
    logic [2:0] err_code;

    // bench-side bus agents
    logic o_sda = 1'b0, o_scl = 1'b0;
    logic ack_addr = 1'b1, ack_data = 1'b1, stretch_en = 1'b0, jam_en = 1'b0;
    int   jam_at = 1;
    logic clr_mon = 1'b0;
    logic sl_ack = 1'b0, sl_jam = 1'b0;
    int   st_cnt = 0;

    wire scl_line = ~(scl_oe | (st_cnt != 0) | o_scl);
    wire sda_line = ~(sda_oe | sl_ack | sl_jam | o_sda);

    always #5 clk = ~clk;

    twm_writer #(.HALF(HALF), .STUCK_MAX(STUCK_MAX)) u_twm_writer (
        .clk(clk), .rst(rst), .req(req), .addr(addr_i), .data(data_i),
        .busy(busy), .done(done), .err_flag(err_flag), .err_code(err_code),
        .arb_lost(arb_lost), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe));

    // slave model and bus monitor
    logic sp = 1'b1, dp = 1'b1;
    int   bitcnt = 0, nbytes = 0;
    logic [7:0] shreg = '0;
    logic [7:0] cap [4];
    int   start_cnt = 0, stop_cnt = 0, rise_cnt = 0, cur_high = 0, min_high = 1000;

    always @(posedge clk) begin
        sp <= scl_line;
        dp <= sda_line;
        if (!jam_en) sl_jam <= 1'b0;
        if (st_cnt != 0) st_cnt <= st_cnt - 1;
        if (sp && scl_line && dp && !sda_line) begin
            start_cnt <= start_cnt + 1;
            bitcnt <= 0; nbytes <= 0; sl_ack <= 1'b0;
        end else if (sp && scl_line && !dp && sda_line) begin
            stop_cnt <= stop_cnt + 1;
        end else if (!sp && scl_line) begin
            rise_cnt <= rise_cnt + 1;
            if (bitcnt < 8) shreg <= {shreg[6:0], sda_line};
            bitcnt <= bitcnt + 1;
        end else if (sp && !scl_line) begin
            if (bitcnt == 8) begin
                if (nbytes < 4) cap[nbytes] <= shreg;
                nbytes <= nbytes + 1;
                if ((nbytes == 0) ? ack_addr : ack_data) sl_ack <= 1'b1;
                if (stretch_en && nbytes == 0) st_cnt <= STRETCH;
            end else if (bitcnt == 9) begin
                sl_ack <= 1'b0;
                bitcnt <= 0;
                if (jam_en && nbytes == jam_at) sl_jam <= 1'b1;
            end
        end
        if (clr_mon) begin
            min_high <= 1000; cur_high <= 0;
        end else if (scl_line) cur_high <= cur_high + 1;
        else begin
            if (sp && cur_high < min_high) min_high <= cur_high;
            cur_high <= 0;
        end
    end

    int nchk = 0, nerr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic pulse_req(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); addr_i = a; data_i = d; req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done == 1'b1, {tag, " done seen"}, int'(done), 1);
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int s0, p0, r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4, R11: reset state
        eq("R4 reset oe", {scl_oe, sda_oe}, 0);
        eq("R11 reset busy/done", {busy, done}, 0);
        eq("R10 reset error", {err_flag, err_code}, 0);

        // R3 R1 R5: sweep of address/data pairs
        for (int i = 0; i < 8; i++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = 7'((i * 37 + 5) & 127);
            d = 8'((i * 73) ^ 8'hA5);
            clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
            s0 = start_cnt; p0 = stop_cnt;
            pulse_req(a, d);
            eq("R11 busy after accept", int'(busy), 1);
            if (i == 0) begin
                repeat (30) @(negedge clk);
                pulse_req(7'h11, 8'h22);   // R11: ignored while busy
            end
            wait_done("R3 sweep");
            @(negedge clk);
            eq("R11 done one cycle", int'(done), 0);
            eq("R3 address byte", int'(cap[0]), int'({a, 1'b0}));
            eq("R3 data byte", int'(cap[1]), int'(d));
            eq("R10 no fault", int'(err_flag), 0);
            eq("R1 one START", start_cnt - s0, 1);
            eq("R1 one STOP", stop_cnt - p0, 1);
            chk(min_high >= HALF, "R5 min SCL high", min_high, HALF);
            settle();
        end

        // R2: another master holds the bus
        @(negedge clk); o_sda = 1'b1;
        repeat (3) @(negedge clk);
        pulse_req(7'h3C, 8'h5A);
        begin
            int moved = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (scl_oe || sda_oe) moved = 1;
            end
            eq("R2 stays off busy bus", moved, 0);
            eq("R2 still busy", int'(busy), 1);
        end
        o_sda = 1'b0;
        wait_done("R2");
        eq("R2 data after STOP", int'(cap[1]), 8'h5A);
        settle();

        // R5: clock stretch below the watchdog
        stretch_en = 1'b1;
        clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
        pulse_req(7'h7F, 8'h81);
        wait_done("R5");
        eq("R5 stretched address", int'(cap[0]), 8'hFE);
        eq("R5 stretched data", int'(cap[1]), 8'h81);
        eq("R5 no fault under stretch", int'(err_flag), 0);
        chk(min_high >= HALF, "R5 min SCL high stretched", min_high, HALF);
        stretch_en = 1'b0;
        settle();

        // R8: address refused
        ack_addr = 1'b0;
        p0 = stop_cnt;
        pulse_req(7'h2A, 8'hC3);
        wait_done("R8");
        eq("R8 code 3", int'(err_code), 3);
        eq("R8 flag", int'(err_flag), 1);
        eq("R8 no data byte", nbytes, 1);
        eq("R8 STOP issued", stop_cnt - p0, 1);
        settle();

        // R10: refused address then SDA jammed at STOP keeps code 3
        jam_en = 1'b1; jam_at = 1;
        pulse_req(7'h2A, 8'hC3);
        wait_done("R10");
        eq("R10 first fault kept", int'(err_code), 3);
        @(negedge clk); jam_en = 1'b0;
        ack_addr = 1'b1;
        settle();

        // R9: SDA jammed during STOP
        jam_en = 1'b1; jam_at = 2;
        pulse_req(7'h06, 8'h60);
        wait_done("R9");
        eq("R9 code 4", int'(err_code), 4);
        eq("R9 data delivered", int'(cap[1]), 8'h60);
        @(negedge clk); jam_en = 1'b0;
        settle();

        // R6: arbitration lost on first address bit
        ack_addr = 1'b0;
        r0 = rise_cnt; p0 = stop_cnt;
        pulse_req(7'h55, 8'hAA);
        while (sda_line) @(negedge clk);
        while (scl_line) @(negedge clk);
        o_sda = 1'b1;
        wait_done("R6");
        eq("R6 code 2", int'(err_code), 2);
        eq("R6 arb flag", int'(arb_lost), 1);
        eq("R6 clocks to byte end", rise_cnt - r0, 9);
        eq("R6 no own STOP", stop_cnt - p0, 0);
        @(negedge clk);
        eq("R6 lines released", {scl_oe, sda_oe}, 0);
        o_sda = 1'b0;
        ack_addr = 1'b1;
        settle();

        // R7: SCL held low by another device
        o_scl = 1'b1;
        pulse_req(7'h01, 8'h02);
        wait_done("R7");
        eq("R7 code 1", int'(err_code), 1);
        @(negedge clk);
        eq("R7 lines released", {scl_oe, sda_oe}, 0);
        o_scl = 1'b0;
        settle();

        // R10: new request clears the fault
        pulse_req(7'h40, 8'h0F);
        @(negedge clk);
        eq("R10 cleared on accept", {err_flag, err_code, arb_lost}, 0);
        wait_done("R10 clean");
        eq("R10 clean data", int'(cap[1]), 8'h0F);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule